// File: doc/BRIEF.md
# Configuration Access Address Translator

This block takes one configuration request at a time and turns it into a single data access, or two, on a plain request/response memory port. A request names a bus, a device, a function, a byte offset into that function's configuration space, a direction, an access size and write data. Some bus/device pairs can never hold a device. The block filters these out before any downstream traffic: a read of such a pair returns all ones and a write to it is discarded. Requests on bus 0 go to a local register window. Requests on any other bus go to a remote window. Before the remote access, the block programs one translation region with a configuration type and a target routing word.

The dword offset is aligned before it is added to the window base. Byte and halfword writes become a read of the aligned dword, a lane merge and a write back. A remote read that gets an error response reads as all ones, so software never sees undefined data. A sub-dword write whose read phase faults is dropped. The requester holds `req_valid` until `req_ready` pulses for one cycle. `rsp_rdata` is valid from that cycle until the next request.

Top module: `cfgx_translator`

## Requirements
- R1: Only these bus/device pairs are legal: bus 0 with device 0 or 1, bus 1 with device 0, and any device on bus 2 and above.
- R2: A read of an illegal pair returns 32'hFFFFFFFF. It makes no memory access and does no region programming.
- R3: A write to an illegal pair is discarded. It makes no memory access and does no region programming.
- R4: Bus 0 requests use the local window base and do not program the translation region.
- R5: Requests on bus 1 or above program the region exactly once before the first memory access. The type code is 4 for bus 1 and 5 for bus 2 and above. The target word is bus in bits 31:24, device in bits 23:19 and function in bits 18:16, with all other bits zero.
- R6: The memory address is the window base plus the offset with its two low bits cleared, so it is always dword aligned.
- R7: A read that gets an error response returns 32'hFFFFFFFF.
- R8: A byte write (size 0) or halfword write (size 1) reads the aligned dword and then writes it back with the new lanes merged. The byte enable is 1 shifted left by offset[1:0] for a byte, and 2'b11 shifted left by 2*offset[1] for a halfword. The value is taken right-aligned from req_wdata and placed in those lanes.
- R9: A dword write (size 2) makes exactly one write with byte enable 4'b1111 and no read.
- R10: Every request ends with req_ready high for exactly one cycle, after the last memory response.
- R11: While reset is held and in the cycle after it, mem_req, xlt_wr and req_ready are low.
- R12: If the read phase of a sub-dword write gets an error response, no write is issued.
- R13: The memory request and its address are held stable until the response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present, held until req_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 dword |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_off | input | 12 | Byte offset into configuration space |
| req_wdata | input | 32 | Write value, right-aligned |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read result |
| xlt_wr | output | 1 | Region programming strobe |
| xlt_type | output | 3 | Configuration type code for the region |
| xlt_target | output | 32 | Routing target word for the region |
| mem_req | output | 1 | Memory access request, held until mem_rvalid |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Byte address, dword aligned |
| mem_be | output | 4 | Byte enables of a write |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Memory response |
| mem_err | input | 1 | Error flag with the response |
| mem_rdata | input | 32 | Read data with the response |

## Verification
Some properties are checked on every cycle. Addresses must stay dword aligned. The request and address must be held until the response. Region programming must be followed by an access. A rejected pair must cause no downstream activity, and a faulted read phase must not lead to a write. Dword writes must carry full enables. The completion pulse must last one cycle, and the block must be quiet in reset. Other behaviour can only be shown by the bench's scenarios against a memory model: which bus/device pairs are accepted, the type and target values, the merged read-back contents after byte and halfword writes, and the all-ones results of rejected and faulting reads.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CHECK = 3'd1,
    ST_PROG  = 3'd2,
    ST_RD    = 3'd3,
    ST_MRG   = 3'd4,
    ST_WR    = 3'd5,
    ST_DONE  = 3'd6
  } seq_state_t;

  localparam logic [2:0] TYPE_NEAR = 3'd4;  // buses 0 and 1
  localparam logic [2:0] TYPE_FAR  = 3'd5;  // buses 2 and above

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

endpackage

// File: rtl/cfgx_filter.sv
module cfgx_filter #(
  parameter int BUS_W   = 8,
  parameter int DEV_W   = 5,
  parameter int FN_W    = 3,
  parameter int TGT_W   = 32,
  parameter int TGT_LSB = 16
) (
  input  logic [BUS_W-1:0] bus,
  input  logic [DEV_W-1:0] dev,
  input  logic [FN_W-1:0]  fn,
  output logic             legal,
  output logic             remote,
  output logic [2:0]       rtype,
  output logic [TGT_W-1:0] target
);
  import cfgx_pkg::*;

  localparam int RID_W = BUS_W + DEV_W + FN_W;

  logic [RID_W-1:0] rid;
  logic             bus_zero;
  logic             bus_one;
  logic             dev_zero;

  assign rid      = {bus, dev, fn};
  assign bus_zero = (bus == '0);
  assign bus_one  = (bus == BUS_W'(1));
  assign dev_zero = (dev == '0);

  always_comb begin
    if (bus_zero)      legal = (dev <= DEV_W'(1));
    else if (bus_one)  legal = dev_zero;
    else               legal = 1'b1;
  end

  assign remote = !bus_zero;
  assign rtype  = (bus_zero || bus_one) ? TYPE_NEAR : TYPE_FAR;
  assign target = TGT_W'(rid) << TGT_LSB;

endmodule

// File: rtl/cfgx_lanes.sv
module cfgx_lanes #(
  parameter int DATA_W = 32
) (
  input  logic [1:0]          off_lo,
  input  logic [1:0]          size,
  input  logic [DATA_W-1:0]   value,
  input  logic [DATA_W-1:0]   old_word,
  output logic [DATA_W/8-1:0] be,
  output logic [DATA_W-1:0]   merged
);
  import cfgx_pkg::*;

  localparam int NB = DATA_W / 8;

  logic [1:0]        lane;
  logic [DATA_W-1:0] placed;

  always_comb begin
    case (size)
      SZ_BYTE: begin lane = off_lo;              be = NB'(1) << off_lo; end
      SZ_HALF: begin lane = {off_lo[1], 1'b0};   be = NB'(3) << lane;   end
      default: begin lane = 2'd0;                be = '1;               end
    endcase
  end

  assign placed = value << (lane * 8);

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign merged[g*8 +: 8] = be[g] ? placed[g*8 +: 8] : old_word[g*8 +: 8];
  end

endmodule

// File: rtl/cfgx_seq.sv
module cfgx_seq (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 legal,
  input  logic                 remote,
  input  logic                 is_wr,
  input  logic                 partial,
  input  logic                 mem_rvalid,
  input  logic                 mem_err,
  output cfgx_pkg::seq_state_t st,
  output logic                 xlt_wr,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic                 req_ready
);
  import cfgx_pkg::*;

  logic direct_wr;
  assign direct_wr = is_wr && !partial;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      xlt_wr    <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      req_ready <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) st <= ST_CHECK;
        ST_CHECK: begin
          if (!legal) begin
            st        <= ST_DONE;
            req_ready <= 1'b1;
          end else if (remote) begin
            st     <= ST_PROG;
            xlt_wr <= 1'b1;
          end else begin
            st      <= direct_wr ? ST_WR : ST_RD;
            mem_req <= 1'b1;
            mem_we  <= direct_wr;
          end
        end
        ST_PROG: begin
          xlt_wr  <= 1'b0;
          st      <= direct_wr ? ST_WR : ST_RD;
          mem_req <= 1'b1;
          mem_we  <= direct_wr;
        end
        ST_RD: if (mem_rvalid) begin
          mem_req <= 1'b0;
          if (is_wr && !mem_err) begin
            st <= ST_MRG;
          end else begin
            st        <= ST_DONE;
            req_ready <= 1'b1;
          end
        end
        ST_MRG: begin
          st      <= ST_WR;
          mem_req <= 1'b1;
          mem_we  <= 1'b1;
        end
        ST_WR: if (mem_rvalid) begin
          mem_req   <= 1'b0;
          mem_we    <= 1'b0;
          st        <= ST_DONE;
          req_ready <= 1'b1;
        end
        ST_DONE: begin
          req_ready <= 1'b0;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R11: quiet in and just after reset
  a_r11_reset_quiet: assert property (@(posedge clk)
    rst |=> (!mem_req && !req_ready && !xlt_wr));

  // R10: completion is a single-cycle pulse
  a_r10_ready_single: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !req_ready);

  // R5: region programming is followed at once by the access
  a_r5_prog_then_access: assert property (@(posedge clk) disable iff (rst)
    xlt_wr |=> (mem_req && !xlt_wr));

  // R12: a faulted read phase never leads to a write
  a_r12_fault_no_write: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RD && mem_rvalid && mem_err) |=> ##1 !mem_req);

  // R13: request held until answered
  a_r13_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rvalid) |=> mem_req);

endmodule

// File: rtl/cfgx_translator.sv
module cfgx_translator #(
  parameter int          BUS_W       = 8,
  parameter int          DEV_W       = 5,
  parameter int          FN_W        = 3,
  parameter int          OFF_W       = 12,
  parameter int          ADDR_W      = 32,
  parameter int          DATA_W      = 32,
  parameter int          TGT_LSB     = 16,
  parameter logic [31:0] LOCAL_BASE  = 32'h4000_0000,
  parameter logic [31:0] REMOTE_BASE = 32'h5000_0000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [1:0]           req_size,
  input  logic [BUS_W-1:0]     req_bus,
  input  logic [DEV_W-1:0]     req_dev,
  input  logic [FN_W-1:0]      req_func,
  input  logic [OFF_W-1:0]     req_off,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 req_ready,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 xlt_wr,
  output logic [2:0]           xlt_type,
  output logic [ADDR_W-1:0]    xlt_target,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [DATA_W/8-1:0]  mem_be,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic                 mem_rvalid,
  input  logic                 mem_err,
  input  logic [DATA_W-1:0]    mem_rdata
);
  import cfgx_pkg::*;

  localparam int NB = DATA_W / 8;

  seq_state_t st;

  logic             wr_q;
  logic [1:0]       size_q;
  logic [BUS_W-1:0] bus_q;
  logic [DEV_W-1:0] dev_q;
  logic [FN_W-1:0]  fn_q;
  logic [OFF_W-1:0] off_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  logic              legal, remote, partial;
  logic [2:0]        rtype;
  logic [ADDR_W-1:0] target;
  logic [NB-1:0]     lane_be;
  logic [DATA_W-1:0] merged;
  logic [ADDR_W-1:0] aligned_off;

  assign partial     = (size_q == SZ_BYTE) || (size_q == SZ_HALF);
  assign aligned_off = ADDR_W'({off_q[OFF_W-1:2], 2'b00});

  cfgx_filter #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W),
    .TGT_W(ADDR_W), .TGT_LSB(TGT_LSB)
  ) u_filter (
    .bus(bus_q), .dev(dev_q), .fn(fn_q),
    .legal(legal), .remote(remote), .rtype(rtype), .target(target)
  );

  cfgx_lanes #(.DATA_W(DATA_W)) u_lanes (
    .off_lo(off_q[1:0]), .size(size_q), .value(wdata_q),
    .old_word(rdata_q), .be(lane_be), .merged(merged)
  );

  cfgx_seq u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid),
    .legal(legal), .remote(remote), .is_wr(wr_q), .partial(partial),
    .mem_rvalid(mem_rvalid), .mem_err(mem_err),
    .st(st), .xlt_wr(xlt_wr), .mem_req(mem_req), .mem_we(mem_we),
    .req_ready(req_ready)
  );

  // request capture
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q   <= 1'b0;
      size_q <= '0;
      bus_q  <= '0;
      dev_q  <= '0;
      fn_q   <= '0;
      off_q  <= '0;
    end else if (st == ST_IDLE && req_valid) begin
      wr_q   <= req_write;
      size_q <= req_size;
      bus_q  <= req_bus;
      dev_q  <= req_dev;
      fn_q   <= req_func;
      off_q  <= req_off;
    end
  end

  // datapath toward the region and memory port
  always_ff @(posedge clk) begin
    if (rst) begin
      wdata_q    <= '0;
      rdata_q    <= '0;
      mem_addr   <= '0;
      mem_be     <= '0;
      mem_wdata  <= '0;
      xlt_type   <= '0;
      xlt_target <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) wdata_q <= req_wdata;
        ST_CHECK: begin
          mem_addr   <= (remote ? REMOTE_BASE : LOCAL_BASE) + aligned_off;
          mem_be     <= '1;
          mem_wdata  <= wdata_q;
          xlt_type   <= rtype;
          xlt_target <= target;
          if (!legal) rdata_q <= '1;
        end
        ST_RD: if (mem_rvalid) rdata_q <= mem_err ? '1 : mem_rdata;
        ST_MRG: begin
          mem_be    <= lane_be;
          mem_wdata <= merged;
        end
        default: ;
      endcase
    end
  end

  assign rsp_rdata = rdata_q;

  // R6: addresses always dword aligned
  a_r6_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R13: address held while waiting
  a_r13_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rvalid) |=> $stable(mem_addr));

  // R9: dword writes carry every byte enable
  a_r9_full_be: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && !partial) |-> (mem_be == '1));

  // R2 / R3: rejected pair causes no downstream activity
  a_r2_r3_reject_quiet: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CHECK && !legal) |=> (!mem_req && !xlt_wr && req_ready));

endmodule

// File: tb/sim_cfgx_translator.sv
module sim_cfgx_translator;

  localparam logic [31:0] LBASE = 32'h4000_0000;
  localparam logic [31:0] RBASE = 32'h5000_0000;
  localparam logic [7:0]  FAULT_BUS = 8'h33;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic [1:0]  req_size = 2;
  logic [7:0]  req_bus = 0;
  logic [4:0]  req_dev = 0;
  logic [2:0]  req_func = 0;
  logic [11:0] req_off = 0;
  logic [31:0] req_wdata = 0;
  logic        req_ready;
  logic [31:0] rsp_rdata;
  logic        xlt_wr;
  logic [2:0]  xlt_type;
  logic [31:0] xlt_target;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_rvalid, mem_err;
  logic [31:0] mem_rdata;

  cfgx_translator u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_bus(req_bus), .req_dev(req_dev),
    .req_func(req_func), .req_off(req_off), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_rdata(rsp_rdata), .xlt_wr(xlt_wr),
    .xlt_type(xlt_type), .xlt_target(xlt_target), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_err(mem_err),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] pat(input logic rem, input int idx);
    return rem ? 32'h2000_0000 + idx * 32'h0303 : 32'h1000_0000 + idx * 32'h0101;
  endfunction

  // memory and region model
  logic [31:0] lmem [32];
  logic [31:0] rmem [32];
  logic [2:0]  m_type;
  logic [31:0] m_target;
  int n_prog, n_rd, n_wr;
  logic [31:0] last_addr;
  logic [3:0]  last_be;

  always @(posedge clk) begin
    if (rst) begin
      mem_rvalid <= 0; mem_err <= 0; mem_rdata <= 0;
      n_prog <= 0; n_rd <= 0; n_wr <= 0;
      m_type <= 0; m_target <= 0; last_addr <= 0; last_be <= 0;
      for (int i = 0; i < 32; i++) begin
        lmem[i] <= pat(1'b0, i);
        rmem[i] <= pat(1'b1, i);
      end
    end else begin
      if (xlt_wr) begin
        m_type <= xlt_type; m_target <= xlt_target; n_prog <= n_prog + 1;
      end
      if (mem_req && !mem_rvalid) begin
        logic rem, bad;
        logic [31:0] mask, old;
        rem  = (mem_addr >= RBASE);
        bad  = rem && (m_target[31:24] == FAULT_BUS);
        old  = rem ? rmem[mem_addr[6:2]] : lmem[mem_addr[6:2]];
        mask = {{8{mem_be[3]}}, {8{mem_be[2]}}, {8{mem_be[1]}}, {8{mem_be[0]}}};
        mem_rvalid <= 1; mem_err <= bad;
        last_addr <= mem_addr; last_be <= mem_be;
        if (mem_we) begin
          n_wr <= n_wr + 1;
          if (!bad) begin
            if (rem) rmem[mem_addr[6:2]] <= (old & ~mask) | (mem_wdata & mask);
            else     lmem[mem_addr[6:2]] <= (old & ~mask) | (mem_wdata & mask);
          end
        end else begin
          n_rd <= n_rd + 1;
          mem_rdata <= bad ? 32'h0BAD_0BAD : old;
        end
      end else begin
        mem_rvalid <= 0; mem_err <= 0;
      end
    end
  end

  int checks = 0, failures = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  int ready_cycles;
  logic [31:0] rd_val;

  task automatic do_req(input bit wr, input logic [1:0] sz, input logic [7:0] b,
                        input logic [4:0] d, input logic [2:0] f,
                        input logic [11:0] o, input logic [31:0] wd);
    int wait_n = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_size = sz; req_bus = b;
    req_dev = d; req_func = f; req_off = o; req_wdata = wd;
    ready_cycles = 0;
    do begin
      @(negedge clk);
      wait_n++;
    end while (!req_ready && wait_n < 200);
    if (!req_ready) begin
      check(0, "watchdog", 0, 1);
    end else begin
      ready_cycles = 1;
      rd_val = rsp_rdata;
    end
    req_valid = 0;
    @(negedge clk);
    if (req_ready) ready_cycles++;
  endtask

  // table: bus, dev, fn, off, legal, remote, type
  localparam int NV = 8;
  localparam logic [32:0] VEC [NV] = '{
    {8'd0,   5'd0,  3'd0, 12'h000, 1'b1, 1'b0, 3'd0},
    {8'd0,   5'd1,  3'd3, 12'h00A, 1'b1, 1'b0, 3'd0},
    {8'd0,   5'd2,  3'd0, 12'h004, 1'b0, 1'b0, 3'd0},
    {8'd0,   5'd31, 3'd1, 12'h008, 1'b0, 1'b0, 3'd0},
    {8'd1,   5'd0,  3'd7, 12'h014, 1'b1, 1'b1, 3'd4},
    {8'd1,   5'd1,  3'd0, 12'h018, 1'b0, 1'b1, 3'd0},
    {8'd2,   5'd5,  3'd2, 12'h03F, 1'b1, 1'b1, 3'd5},
    {8'd255, 5'd31, 3'd7, 12'h07C, 1'b1, 1'b1, 3'd5}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state, including first cycle after release
    check(!mem_req && !xlt_wr && !req_ready, "R11 outputs in reset", {mem_req, xlt_wr, req_ready}, 0);
    rst = 0;
    @(negedge clk);
    check(!mem_req && !xlt_wr && !req_ready, "R11 after reset", {mem_req, xlt_wr, req_ready}, 0);

    // table walk of reads: R1 R2 R4 R5 R6 R10
    for (int k = 0; k < NV; k++) begin
      logic [7:0] b; logic [4:0] d; logic [2:0] f; logic [11:0] o;
      logic ok, rem; logic [2:0] ty; int p0, r0;
      logic [31:0] exp_d, exp_t;
      {b, d, f, o, ok, rem, ty} = VEC[k];
      p0 = n_prog; r0 = n_rd;
      do_req(0, 2'd2, b, d, f, o, 0);
      exp_d = ok ? pat(rem, int'(o[6:2])) : 32'hFFFF_FFFF;
      check(rd_val == exp_d, $sformatf("R1/R2 read data vec %0d", k), rd_val, exp_d);
      check((n_rd - r0) == (ok ? 1 : 0), $sformatf("R2 access count vec %0d", k), n_rd - r0, ok);
      check(ready_cycles == 1, $sformatf("R10 ready width vec %0d", k), ready_cycles, 1);
      if (ok) begin
        logic [31:0] exp_a;
        exp_a = (rem ? RBASE : LBASE) + {20'd0, o[11:2], 2'b00};
        check(last_addr == exp_a, $sformatf("R6 address vec %0d", k), last_addr, exp_a);
      end
      if (ok && rem) begin
        exp_t = {b, d, f, 16'h0000};
        check(n_prog - p0 == 1, $sformatf("R5 program count vec %0d", k), n_prog - p0, 1);
        check(m_type == ty, $sformatf("R5 type vec %0d", k), m_type, ty);
        check(m_target == exp_t, $sformatf("R5 target vec %0d", k), m_target, exp_t);
      end else begin
        check(n_prog == p0, $sformatf("R4 no programming vec %0d", k), n_prog - p0, 0);
      end
    end

    // R9: dword write to bus 0 device 1, then read back
    begin
      int w0, r0;
      w0 = n_wr; r0 = n_rd;
      do_req(1, 2'd2, 8'd0, 5'd1, 3'd0, 12'h020, 32'hDEAD_BEEF);
      check(n_wr - w0 == 1 && n_rd == r0, "R9 single write no read", n_wr - w0, 1);
      check(last_be == 4'hF, "R9 full enables", last_be, 4'hF);
      do_req(0, 2'd2, 8'd0, 5'd1, 3'd0, 12'h020, 0);
      check(rd_val == 32'hDEAD_BEEF, "R9 readback", rd_val, 32'hDEAD_BEEF);
    end

    // R8: byte write at offset 0x41 (lane 1) on bus 2
    begin
      int w0, r0;
      w0 = n_wr; r0 = n_rd;
      do_req(1, 2'd0, 8'd2, 5'd0, 3'd0, 12'h041, 32'h0000_005A);
      check(n_rd - r0 == 1 && n_wr - w0 == 1, "R8 byte read-modify-write", n_rd - r0, 1);
      check(last_be == 4'b0010, "R8 byte enable", last_be, 4'b0010);
      do_req(0, 2'd2, 8'd2, 5'd0, 3'd0, 12'h040, 0);
      check(rd_val == 32'h2000_5A30, "R8 byte merge", rd_val, 32'h2000_5A30);
    end

    // R8: halfword write at offset 0x46 (upper half) on bus 1
    begin
      do_req(1, 2'd1, 8'd1, 5'd0, 3'd0, 12'h046, 32'h0000_BEEF);
      check(last_be == 4'b1100, "R8 half enable", last_be, 4'b1100);
      do_req(0, 2'd2, 8'd1, 5'd0, 3'd0, 12'h044, 0);
      check(rd_val == 32'hBEEF_3333, "R8 half merge", rd_val, 32'hBEEF_3333);
    end

    // R3: illegal write dropped
    begin
      int w0, p0, r0;
      w0 = n_wr; p0 = n_prog; r0 = n_rd;
      do_req(1, 2'd2, 8'd1, 5'd3, 3'd0, 12'h020, 32'h1234_5678);
      check(n_wr == w0 && n_rd == r0 && n_prog == p0, "R3 illegal write quiet", n_wr - w0, 0);
      check(ready_cycles == 1, "R10 ready on dropped write", ready_cycles, 1);
    end

    // R7: faulting remote read
    begin
      int r0;
      r0 = n_rd;
      do_req(0, 2'd2, FAULT_BUS, 5'd4, 3'd1, 12'h010, 0);
      check(n_rd - r0 == 1, "R7 fault read issued", n_rd - r0, 1);
      check(rd_val == 32'hFFFF_FFFF, "R7 fault read ones", rd_val, 32'hFFFF_FFFF);
    end

    // R12: sub-dword write whose read faults
    begin
      int w0, r0;
      w0 = n_wr; r0 = n_rd;
      do_req(1, 2'd0, FAULT_BUS, 5'd0, 3'd0, 12'h013, 32'h0000_0077);
      check(n_rd - r0 == 1, "R12 read phase issued", n_rd - r0, 1);
      check(n_wr == w0, "R12 write suppressed", n_wr - w0, 0);
      check(ready_cycles == 1, "R10 ready after fault", ready_cycles, 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule